// File: doc/BRIEF.md
# Bunch-Crossing Hit Recorder with Serial Readout

The block records detector activity for one readout chip during an acquisition window. On every bunch crossing it takes one discriminator code per channel, the running crossing counter and the chip identifier. If at least one channel reports a non-zero code, it packs these into one event word and appends it to an internal event store. When the store holds its full depth of events, it accepts no further events and raises a full flag that stays set until reset.

After the window closes, a start pulse begins the readout. The stored events leave on a single serial line in the order they were written, most significant bit first. Each bit is held for a fixed number of core clock cycles, which gives a readout rate well below the core clock. A strobe marks the first cycle of every bit. A one-cycle end pulse closes the transfer, so the next chip on a shared line can take its turn. With the default sizes an event is 160 bits: an 8-bit header carrying the chip identifier, a 24-bit crossing number and 2 bits for each of 64 channels. The store holds 128 events.

Top module: `hit_mem_recorder`

## Requirements
- R1: An event word is `{chip_id, bc_id, hit_codes}`. The header is the top HDR_W bits, the crossing number comes next, and channel c's code sits at bits [CODE_W*c+CODE_W-1 : CODE_W*c] of the low field.
- R2: A crossing is stored only when `bc_valid` is high and at least one channel code is non-zero. A crossing with all codes zero, or with `bc_valid` low, adds no event.
- R3: While `acq_en` is low, no event is stored, whatever the hit inputs are.
- R4: `mem_full` rises at the clock edge that stores the DEPTH-th event. Later hits are dropped. `mem_full` stays high until reset, including across readouts.
- R5: A `ro_start` pulse with `acq_en` low and no readout in progress sends every stored event once, oldest first, MSB first. A `ro_start` pulse while `acq_en` is high is ignored: `ser_frame` stays low and no `ro_end` pulse appears.
- R6: During readout `ser_frame` is high. Each bit stays on `ser_data` for DIV cycles. `ser_strobe` is high in the first of those cycles and low in the others.
- R7: `ro_end` is a one-cycle pulse. It appears in the cycle after `ser_frame` falls, and that is cycle N·EV_W·DIV+1 after the edge that takes `ro_start`. When the store is empty (N = 0), `ro_end` appears in the first cycle after that edge.
- R8: After reset, `mem_full`, `ser_frame`, `ser_strobe`, `ser_data` and `ro_end` are low and the store is empty.
- R9: A `ro_start` pulse during a readout in progress has no effect on its length or content.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset |
| acq_en | input | 1 | Acquisition window open |
| bc_valid | input | 1 | Current crossing's inputs are valid |
| hit_codes | input | NUM_CH*CODE_W | Discriminator code per channel |
| bc_id | input | BC_W | Running crossing number |
| chip_id | input | HDR_W | Chip identifier placed in the header |
| ro_start | input | 1 | Readout start pulse |
| mem_full | output | 1 | Store holds DEPTH events |
| ser_data | output | 1 | Serial event data |
| ser_strobe | output | 1 | First cycle of each serial bit |
| ser_frame | output | 1 | Readout in progress |
| ro_end | output | 1 | Readout finished pulse |

## Verification
The bench builds the recorder with 4 channels, a depth of 4 events and 3 clocks per serial bit, which gives 40-bit events. The small depth lets a few crossings fill the store, so the full flag, dropped hits and a full-depth readout all occur within a short run. The short bit period keeps the exact end-pulse timing cheap to check on every readout, including the empty-store case and a repeated start during a transfer.

// File: rtl/hmr_pkg.sv
package hmr_pkg;

    typedef enum logic {
        SER_IDLE  = 1'b0,
        SER_SHIFT = 1'b1
    } ser_state_e;

endpackage

// File: rtl/hmr_event_writer.sv
module hmr_event_writer #(
    parameter int NUM_CH = 64,
    parameter int CODE_W = 2,
    parameter int BC_W   = 24,
    parameter int HDR_W  = 8,
    parameter int DEPTH  = 128,
    localparam int HIT_W = NUM_CH * CODE_W,
    localparam int EV_W  = HDR_W + BC_W + HIT_W,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acq_en,
    input  logic             bc_valid,
    input  logic [HIT_W-1:0] hit_codes,
    input  logic [BC_W-1:0]  bc_id,
    input  logic [HDR_W-1:0] chip_id,
    output logic             wr_en,
    output logic [AW-1:0]    wr_addr,
    output logic [EV_W-1:0]  wr_word,
    output logic [CW-1:0]    ev_count,
    output logic             full
);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          full;
    } wr_state_t;

    wr_state_t s_d, s_q;
    logic      any_hit;

    always_comb begin
        s_d     = s_q;
        any_hit = |hit_codes;
        wr_en   = acq_en & bc_valid & any_hit & ~s_q.full;
        if (wr_en) begin
            s_d.cnt  = s_q.cnt + 1'b1;
            s_d.full = ((s_q.cnt + 1'b1) == CW'(DEPTH));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign wr_addr  = s_q.cnt[AW-1:0];
    assign wr_word  = {chip_id, bc_id, hit_codes};
    assign ev_count = s_q.cnt;
    assign full     = s_q.full;

    AST_FULL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        full |=> full); // R4
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        ev_count <= CW'(DEPTH)); // R4
    AST_NO_WRITE_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
        !acq_en |=> $stable(ev_count)); // R3
    AST_NO_EMPTY_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_codes == '0) |=> $stable(ev_count)); // R2

endmodule

// File: rtl/hmr_event_store.sv
module hmr_event_store #(
    parameter int WIDTH = 160,
    parameter int DEPTH = 128,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [AW-1:0]    rd_addr,
    output logic [WIDTH-1:0] rd_data
);

    logic [WIDTH-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem_q[rd_addr];

endmodule

// File: rtl/hmr_serializer.sv
module hmr_serializer
    import hmr_pkg::*;
#(
    parameter int EV_W  = 160,
    parameter int DEPTH = 128,
    parameter int DIV   = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int BW   = $clog2(EV_W),
    localparam int DW   = (DIV > 1) ? $clog2(DIV) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            acq_en,
    input  logic            ro_start,
    input  logic [CW-1:0]   ev_count,
    output logic [AW-1:0]   rd_addr,
    input  logic [EV_W-1:0] rd_data,
    output logic            ser_data,
    output logic            ser_strobe,
    output logic            ser_frame,
    output logic            ro_end
);

    typedef struct packed {
        ser_state_e      st;
        logic [EV_W-1:0] shift;
        logic [CW-1:0]   n;
        logic [CW-1:0]   rd_idx;
        logic [BW-1:0]   bit_cnt;
        logic [DW-1:0]   div_cnt;
        logic            end_p;
    } ser_reg_t;

    ser_reg_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.end_p = 1'b0;
        case (s_q.st)
            SER_IDLE: begin
                if (ro_start && !acq_en) begin
                    if (ev_count == '0) begin
                        s_d.end_p = 1'b1;
                    end else begin
                        s_d.st      = SER_SHIFT;
                        s_d.shift   = rd_data;
                        s_d.n       = ev_count;
                        s_d.rd_idx  = CW'(1);
                        s_d.bit_cnt = '0;
                        s_d.div_cnt = '0;
                    end
                end
            end
            SER_SHIFT: begin
                if (s_q.div_cnt == DW'(DIV - 1)) begin
                    s_d.div_cnt = '0;
                    if (s_q.bit_cnt == BW'(EV_W - 1)) begin
                        s_d.bit_cnt = '0;
                        if (s_q.rd_idx == s_q.n) begin
                            s_d.st     = SER_IDLE;
                            s_d.rd_idx = '0;
                            s_d.shift  = '0;
                            s_d.end_p  = 1'b1;
                        end else begin
                            s_d.shift  = rd_data;
                            s_d.rd_idx = s_q.rd_idx + 1'b1;
                        end
                    end else begin
                        s_d.shift   = {s_q.shift[EV_W-2:0], 1'b0};
                        s_d.bit_cnt = s_q.bit_cnt + 1'b1;
                    end
                end else begin
                    s_d.div_cnt = s_q.div_cnt + 1'b1;
                end
            end
            default: s_d.st = SER_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ser_frame  = (s_q.st == SER_SHIFT);
    assign ser_data   = ser_frame & s_q.shift[EV_W-1];
    assign ser_strobe = ser_frame & (s_q.div_cnt == '0);
    assign ro_end     = s_q.end_p;
    assign rd_addr    = s_q.rd_idx[AW-1:0];

    AST_END_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ro_end |=> !ro_end); // R7
    AST_END_AFTER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ser_frame) |-> ro_end); // R7
    AST_END_OUTSIDE_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        ro_end |-> !ser_frame); // R7
    AST_STROBE_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        ((DIV > 1) && ser_strobe) |=> !ser_strobe); // R6
    AST_BIT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_frame && !ser_strobe) |-> $stable(ser_data)); // R6
    AST_NO_START_IN_ACQ: assert property (@(posedge clk) disable iff (!rst_n)
        (!ser_frame && acq_en) |=> !ser_frame); // R5

endmodule

// File: rtl/hit_mem_recorder.sv
module hit_mem_recorder #(
    parameter int NUM_CH = 64,
    parameter int CODE_W = 2,
    parameter int BC_W   = 24,
    parameter int HDR_W  = 8,
    parameter int DEPTH  = 128,
    parameter int DIV    = 8,
    localparam int HIT_W = NUM_CH * CODE_W,
    localparam int EV_W  = HDR_W + BC_W + HIT_W,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acq_en,
    input  logic             bc_valid,
    input  logic [HIT_W-1:0] hit_codes,
    input  logic [BC_W-1:0]  bc_id,
    input  logic [HDR_W-1:0] chip_id,
    input  logic             ro_start,
    output logic             mem_full,
    output logic             ser_data,
    output logic             ser_strobe,
    output logic             ser_frame,
    output logic             ro_end
);

    logic            wr_en;
    logic [AW-1:0]   wr_addr;
    logic [EV_W-1:0] wr_word;
    logic [CW-1:0]   ev_count;
    logic [AW-1:0]   rd_addr;
    logic [EV_W-1:0] rd_data;

    hmr_event_writer #(
        .NUM_CH (NUM_CH),
        .CODE_W (CODE_W),
        .BC_W   (BC_W),
        .HDR_W  (HDR_W),
        .DEPTH  (DEPTH)
    ) i_writer (
        .clk       (clk),
        .rst_n     (rst_n),
        .acq_en    (acq_en),
        .bc_valid  (bc_valid),
        .hit_codes (hit_codes),
        .bc_id     (bc_id),
        .chip_id   (chip_id),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_word   (wr_word),
        .ev_count  (ev_count),
        .full      (mem_full)
    );

    hmr_event_store #(
        .WIDTH (EV_W),
        .DEPTH (DEPTH)
    ) i_store (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_word),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    hmr_serializer #(
        .EV_W  (EV_W),
        .DEPTH (DEPTH),
        .DIV   (DIV)
    ) i_ser (
        .clk        (clk),
        .rst_n      (rst_n),
        .acq_en     (acq_en),
        .ro_start   (ro_start),
        .ev_count   (ev_count),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .ser_data   (ser_data),
        .ser_strobe (ser_strobe),
        .ser_frame  (ser_frame),
        .ro_end     (ro_end)
    );

endmodule

// File: tb/test_hit_mem_recorder.sv
module test_hit_mem_recorder;

    localparam int NUM_CH = 4;
    localparam int CODE_W = 2;
    localparam int BC_W   = 24;
    localparam int HDR_W  = 8;
    localparam int DEPTH  = 4;
    localparam int DIV    = 3;
    localparam int HIT_W  = NUM_CH * CODE_W;
    localparam int EV_W   = HDR_W + BC_W + HIT_W;
    localparam logic [HDR_W-1:0] CHIP = 8'hA5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             acq_en = 1'b0;
    logic             bc_valid = 1'b0;
    logic [HIT_W-1:0] hit_codes = '0;
    logic [BC_W-1:0]  bc_id = '0;
    logic             ro_start = 1'b0;
    logic             mem_full, ser_data, ser_strobe, ser_frame, ro_end;

    int checks = 0;
    int errors = 0;
    logic [BC_W-1:0]  bc_ctr = 24'h00_1000;
    logic [EV_W-1:0]  stored[$];
    logic [EV_W-1:0]  exp_q[$];
    logic [EV_W-1:0]  mon_sh = '0;
    int               mon_bits = 0;
    logic             last_bit = 1'b0;

    always #2.5 clk = ~clk;

    hit_mem_recorder #(
        .NUM_CH (NUM_CH), .CODE_W (CODE_W), .BC_W (BC_W),
        .HDR_W  (HDR_W),  .DEPTH  (DEPTH),  .DIV  (DIV)
    ) i_hit_mem_recorder (
        .clk (clk), .rst_n (rst_n), .acq_en (acq_en), .bc_valid (bc_valid),
        .hit_codes (hit_codes), .bc_id (bc_id), .chip_id (CHIP),
        .ro_start (ro_start), .mem_full (mem_full), .ser_data (ser_data),
        .ser_strobe (ser_strobe), .ser_frame (ser_frame), .ro_end (ro_end)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: collects serial bits and compares against the scoreboard
    always @(negedge clk) begin
        if (rst_n && ser_frame) begin
            if (ser_strobe) begin
                mon_sh   = {mon_sh[EV_W-2:0], ser_data};
                last_bit = ser_data;
                mon_bits++;
                if (mon_bits == EV_W) begin
                    mon_bits = 0;
                    checks++;
                    if (exp_q.size() == 0) begin
                        errors++;
                        $display("FAIL R5 unexpected event actual=%h expected=none", mon_sh);
                    end else begin
                        logic [EV_W-1:0] e;
                        e = exp_q.pop_front();
                        if (e !== mon_sh) begin
                            errors++;
                            $display("FAIL R1/R5 event actual=%h expected=%h", mon_sh, e);
                        end
                    end
                end
            end else if (ser_data !== last_bit) begin
                checks++;
                errors++;
                $display("FAIL R6 bit not held actual=%0b expected=%0b", ser_data, last_bit);
            end
        end
    end

    // driver: one bunch crossing, model decides whether an event is expected
    task automatic bc(input logic v, input logic [HIT_W-1:0] h);
        bc_valid  = v;
        hit_codes = h;
        bc_id     = bc_ctr;
        if (acq_en && v && (h != '0) && stored.size() < DEPTH)
            stored.push_back({CHIP, bc_ctr, h});
        @(negedge clk);
        bc_ctr    = bc_ctr + 24'd7;
        bc_valid  = 1'b0;
        hit_codes = '0;
    endtask

    task automatic readout(input bit extra_start);
        int k;
        int n;
        n = stored.size();
        foreach (stored[i]) exp_q.push_back(stored[i]);
        ro_start = 1'b1;
        @(negedge clk);
        ro_start = 1'b0;
        k = 1;
        while (!ro_end && k < 5000) begin
            ro_start = (extra_start && k == 50);
            @(negedge clk);
            k++;
        end
        ro_start = 1'b0;
        chk(k == n * EV_W * DIV + 1, "R7 end pulse cycle", k, n * EV_W * DIV + 1);
        chk(!ser_frame, "R7 frame low at end", ser_frame, 0);
        @(negedge clk);
        chk(!ro_end, "R7 end pulse one cycle", ro_end, 0);
        chk(exp_q.size() == 0, "R5 all events sent", exp_q.size(), 0);
        if (extra_start) chk(k == n * EV_W * DIV + 1, "R9 restart ignored", k, n * EV_W * DIV + 1);
        exp_q.delete();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!mem_full && !ser_frame && !ser_strobe && !ser_data && !ro_end,
            "R8 reset outputs", {mem_full, ser_frame, ser_strobe, ser_data, ro_end}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3: hits with the window closed store nothing
        bc(1'b1, 8'h03);
        bc(1'b1, 8'hC1);
        readout(1'b0);   // R7 empty store: end pulse next cycle

        // R2, R1: window open
        acq_en = 1'b1;
        bc(1'b1, 8'h00);     // all zero: dropped (R2)
        bc(1'b0, 8'h22);     // not valid: dropped (R2)
        bc(1'b1, 8'h02);     // channel 0 code 2 (R1)
        bc(1'b1, 8'hC0);     // channel 3 code 3 (R1)
        // R5: start during acquisition ignored
        ro_start = 1'b1;
        @(negedge clk);
        ro_start = 1'b0;
        repeat (4) begin
            chk(!ser_frame && !ro_end, "R5 start ignored in window", {ser_frame, ro_end}, 0);
            @(negedge clk);
        end
        acq_en = 1'b0;
        @(negedge clk);
        chk(!mem_full, "R4 not full yet", mem_full, 0);
        readout(1'b0);       // two events: R1 R5 R6 R7

        // R4: fill the store, extra hits dropped
        acq_en = 1'b1;
        bc(1'b1, 8'h15);
        chk(!mem_full, "R4 full not before depth", mem_full, 0);
        bc(1'b1, 8'h40);
        chk(mem_full, "R4 full at depth", mem_full, 1);
        bc(1'b1, 8'hFF);     // dropped
        bc(1'b1, 8'h08);     // dropped
        acq_en = 1'b0;
        @(negedge clk);
        chk(stored.size() == DEPTH, "R4 model depth", stored.size(), DEPTH);
        readout(1'b1);       // full readout with a repeated start (R9)
        chk(mem_full, "R4 full held after readout", mem_full, 1);
        readout(1'b0);       // second read gives the same events (R5)

        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!mem_full, "R8 full cleared by reset", mem_full, 0);
        stored.delete();
        readout(1'b0);       // R8 store empty after reset

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule